// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block sits behind a flash command decoder. It starts when the decoder reports a complete sector erase command. From then on it gathers the sectors that should be erased together. Each accepted sector sets one bit in a selection bitmap. A programmable quiet window, counted in microsecond ticks, restarts with every added sector. When the window passes with no new command, the block fires a one-cycle erase-start pulse and hands the bitmap to the erase engine.

While the window is open, only two commands have a meaning. A suspend command ends the window at once and parks the block in a held state, without starting the erase. Any other command throws away the collected set and returns the block to read-array mode. A status bit reads low while sectors can still be added and high once the window is over. After the erase has begun, the block ignores everything except suspend. It keeps the bitmap until the erase engine reports the end of the operation.

Top module: `sector_erase_accum`

## Requirements
- R1: After reset, `sector_map` is all zero and `timer_expired`, `erase_start` and `erase_held` are all low.
- R2: In read-array mode, a `se_cmd` strobe opens the window. On the next cycle `sector_map` holds exactly bit `se_sector` and `timer_expired` is low. In this mode, `susp_cmd`, `other_cmd`, `erase_end` and `us_tick` have no effect.
- R3: During the window, each `se_cmd` sets bit `se_sector` of `sector_map` and leaves the other bits unchanged. Sectors may arrive in any order. Repeating a sector that is already set changes nothing. Every sector can be selected.
- R4: The erase begins on the clock edge that samples the TIMEOUT-th `us_tick` after the most recent accepted `se_cmd`. Each accepted `se_cmd` restarts this count from zero.
- R5: `erase_start` is high for exactly one cycle. It goes high in the cycle in which `timer_expired` first goes high, and `sector_map` is kept unchanged.
- R6: A `other_cmd` during the window clears `sector_map` and returns the block to read-array mode, with `timer_expired` low on the next cycle.
- R7: A `susp_cmd` during the window ends it on the next cycle. `timer_expired` and `erase_held` go high, `erase_start` stays low and `sector_map` is kept.
- R8: After the erase has begun, `se_cmd` and `other_cmd` leave `sector_map` and `timer_expired` unchanged. `susp_cmd` raises `erase_held`.
- R9: In the erasing or held state, `erase_end` returns the block to read-array mode and clears `sector_map`. In the held state all commands are ignored.
- R10: When strobes coincide in the window, `other_cmd` takes priority over `susp_cmd`, and `susp_cmd` takes priority over `se_cmd`. A command in the same cycle as the final tick prevents expiry; if that command is `se_cmd`, it restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| se_cmd | input | 1 | Decoded sector erase command strobe |
| se_sector | input | IW | Sector index carried with `se_cmd` |
| susp_cmd | input | 1 | Decoded erase suspend strobe |
| other_cmd | input | 1 | Any other decoded command |
| erase_end | input | 1 | Erase engine finished or aborted |
| sector_map | output | NSEC | One-hot-per-sector selection bitmap |
| timer_expired | output | 1 | High once the accumulation window is over |
| erase_start | output | 1 | One-cycle pulse that starts the erase |
| erase_held | output | 1 | Erase suspended before or during execution |

## Verification
A tick counter that is off by one, or that fails to restart, shows up at the ports as an `erase_start` one tick early, one tick late, or while sectors are still arriving. The bench counts ticks exactly around each restart, so a single missing or extra count is caught within one microsecond of the expected edge. A wrong state decode shows up one cycle after the stimulus in one of three ways: a command that should be ignored changes `sector_map`, a foreign command fails to clear it, or a suspend starts the erase. Coincident strobes, and a sector arriving on the final tick, test the priority order directly.

// File: rtl/sea_pkg.sv
package sea_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_ERASE  = 2'd2,
        ST_HOLD   = 2'd3
    } sea_state_e;

    typedef struct packed {
        sea_state_e state;
        logic       start;
    } sea_ctrl_t;

endpackage

// File: rtl/sea_tick_timer.sv
module sea_tick_timer #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expire = run && tick && !restart && (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (!run || restart) begin
            tmr_d.cnt = '0;
        end else if (tick) begin
            tmr_d.cnt = expire ? '0 : tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/sea_sector_set.sv
module sea_sector_set #(
    parameter int NSEC = 16,
    localparam int IW = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add,
    input  logic [IW-1:0]   idx,
    input  logic            clear,
    output logic [NSEC-1:0] map
);
    typedef struct packed {
        logic [NSEC-1:0] bits;
    } set_t;

    set_t set_d, set_q;
    logic [NSEC-1:0] hit;

    for (genvar g = 0; g < NSEC; g++) begin : g_dec
        assign hit[g] = add && (idx == IW'(g));
    end

    always_comb begin
        set_d = set_q;
        if (clear) set_d.bits = '0;
        else       set_d.bits = set_q.bits | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) set_q <= '0;
        else        set_q <= set_d;
    end

    assign map = set_q.bits;
endmodule

// File: rtl/sector_erase_accum.sv
module sector_erase_accum #(
    parameter int NSEC    = 16,
    parameter int TIMEOUT = 50,
    localparam int IW = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            se_cmd,
    input  logic [IW-1:0]   se_sector,
    input  logic            susp_cmd,
    input  logic            other_cmd,
    input  logic            erase_end,
    output logic [NSEC-1:0] sector_map,
    output logic            timer_expired,
    output logic            erase_start,
    output logic            erase_held
);
    import sea_pkg::*;

    sea_ctrl_t ctl_d, ctl_q;
    logic in_idle, in_win, busy;
    logic add, clear, any_cmd, expire;

    assign in_idle = (ctl_q.state == ST_IDLE);
    assign in_win  = (ctl_q.state == ST_WINDOW);
    assign busy    = (ctl_q.state == ST_ERASE) || (ctl_q.state == ST_HOLD);
    assign any_cmd = se_cmd || susp_cmd || other_cmd;

    assign add   = (in_idle && se_cmd) ||
                   (in_win && se_cmd && !susp_cmd && !other_cmd);
    assign clear = (in_win && other_cmd) || (busy && erase_end);

    sea_tick_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_win),
        .restart (any_cmd),
        .tick    (us_tick),
        .expire  (expire)
    );

    sea_sector_set #(.NSEC(NSEC)) u_set (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (add),
        .idx   (se_sector),
        .clear (clear),
        .map   (sector_map)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (se_cmd) ctl_d.state = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (other_cmd)     ctl_d.state = ST_IDLE;
                else if (susp_cmd) ctl_d.state = ST_HOLD;
                else if (expire) begin
                    ctl_d.state = ST_ERASE;
                    ctl_d.start = 1'b1;
                end
            end
            ST_ERASE: begin
                if (erase_end)     ctl_d.state = ST_IDLE;
                else if (susp_cmd) ctl_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (erase_end)     ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, start: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign timer_expired = busy;
    assign erase_start   = ctl_q.start;
    assign erase_held    = (ctl_q.state == ST_HOLD);
endmodule

// File: rtl/sea_accum_checker.sv
module sea_accum_checker #(
    parameter int NSEC = 16,
    localparam int IW = $clog2(NSEC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            se_cmd,
    input logic [IW-1:0]   se_sector,
    input logic            susp_cmd,
    input logic            other_cmd,
    input logic            erase_end,
    input logic [NSEC-1:0] sector_map,
    input logic            timer_expired,
    input logic            erase_start,
    input logic            erase_held
);
    logic window;
    assign window = (sector_map != '0) && !timer_expired;

    p_idle_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_map == '0 && !timer_expired && se_cmd)
        |=> (sector_map == (NSEC'(1) << $past(se_sector))) && !timer_expired);

    p_map_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (window && !other_cmd)
        |=> ((sector_map & $past(sector_map)) == $past(sector_map)));

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    p_start_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> ($rose(timer_expired) && $stable(sector_map)));

    p_foreign_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (window && other_cmd) |=> (sector_map == '0) && !timer_expired);

    p_suspend_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (window && susp_cmd && !other_cmd)
        |=> timer_expired && erase_held && !erase_start && $stable(sector_map));

    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_expired && !erase_end) |=> timer_expired && $stable(sector_map));

    p_end_returns_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_expired && erase_end) |=> (sector_map == '0) && !timer_expired);

    p_held_is_expired_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_held |-> timer_expired);
endmodule

bind sector_erase_accum sea_accum_checker #(.NSEC(NSEC)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .se_cmd        (se_cmd),
    .se_sector     (se_sector),
    .susp_cmd      (susp_cmd),
    .other_cmd     (other_cmd),
    .erase_end     (erase_end),
    .sector_map    (sector_map),
    .timer_expired (timer_expired),
    .erase_start   (erase_start),
    .erase_held    (erase_held)
);

// File: tb/test_sector_erase_accum.sv
`timescale 1ns/1ps
module test_sector_erase_accum;
    localparam int NSEC = 16;
    localparam int TOUT = 50;
    localparam int IW   = $clog2(NSEC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0, se_cmd = 1'b0, susp_cmd = 1'b0, other_cmd = 1'b0, erase_end = 1'b0;
    logic [IW-1:0] se_sector = '0;
    logic [NSEC-1:0] sector_map;
    logic timer_expired, erase_start, erase_held;

    always #2.5 clk = ~clk;

    sector_erase_accum #(.NSEC(NSEC), .TIMEOUT(TOUT)) i_sector_erase_accum (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .se_cmd(se_cmd),
        .se_sector(se_sector), .susp_cmd(susp_cmd), .other_cmd(other_cmd),
        .erase_end(erase_end), .sector_map(sector_map),
        .timer_expired(timer_expired), .erase_start(erase_start),
        .erase_held(erase_held)
    );

    typedef struct {
        logic [NSEC-1:0] map;
        logic            expd;
        logic            start;
        logic            held;
        string           tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference model: 0 read array, 1 window, 2 erasing, 3 held
    int m_state = 0;
    int m_cnt = 0;
    logic [NSEC-1:0] m_map = '0;

    task automatic push(input logic st, input string tag);
        exp_t e;
        e.map = m_map; e.expd = (m_state >= 2); e.start = st;
        e.held = (m_state == 3); e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input logic se, input int idx, input logic su,
                        input logic ot, input logic en, input logic tk,
                        input string tag);
        logic st;
        @(negedge clk);
        se_cmd = se; se_sector = IW'(idx); susp_cmd = su;
        other_cmd = ot; erase_end = en; us_tick = tk;
        st = 1'b0;
        case (m_state)
            0: if (se) begin m_state = 1; m_map = NSEC'(1) << idx; m_cnt = 0; end
            1: begin
                if (ot)      begin m_state = 0; m_map = '0; end
                else if (su) m_state = 3;
                else if (se) begin m_map[idx] = 1'b1; m_cnt = 0; end
                else if (tk) begin
                    if (m_cnt == TOUT - 1) begin m_state = 2; st = 1'b1; m_cnt = 0; end
                    else m_cnt++;
                end
            end
            2: if (en) begin m_state = 0; m_map = '0; end
               else if (su) m_state = 3;
            default: if (en) begin m_state = 0; m_map = '0; end
        endcase
        push(st, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 0, 0, 1, tag);
            step(0, 0, 0, 0, 0, 0, tag);
        end
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (sector_map !== e.map || timer_expired !== e.expd ||
                    erase_start !== e.start || erase_held !== e.held) begin
                    fails++;
                    $display("FAIL %s: got map=%h exp=%b start=%b held=%b, expected map=%h exp=%b start=%b held=%b",
                             e.tag, sector_map, timer_expired, erase_start, erase_held,
                             e.map, e.expd, e.start, e.held);
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no completion, expected end of stimulus");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (sector_map !== '0 || timer_expired !== 1'b0 || erase_start !== 1'b0 || erase_held !== 1'b0) begin
            fails++;
            $display("FAIL R1: got map=%h exp=%b start=%b held=%b, expected all zero",
                     sector_map, timer_expired, erase_start, erase_held);
        end
        rst_n = 1'b1;

        // R2: idle ignores non-erase inputs
        step(0, 0, 1, 0, 0, 0, "R2 idle suspend");
        step(0, 0, 0, 1, 0, 1, "R2 idle other");
        step(0, 0, 0, 0, 1, 0, "R2 idle end");
        // R2/R3/R4: open, add, restart, duplicate
        step(1, 5, 0, 0, 0, 0, "R2 open");
        ticks(30, "R4 partial");
        step(1, 2, 0, 0, 0, 0, "R3 add out of order");
        step(1, 5, 0, 0, 0, 0, "R3 duplicate");
        ticks(TOUT - 1, "R4 restart window");
        step(0, 0, 0, 0, 0, 1, "R4 R5 final tick");
        step(0, 0, 0, 0, 0, 0, "R5 pulse ends");
        // R8: busy ignores commands, suspend holds
        step(1, 9, 0, 0, 0, 0, "R8 se ignored");
        step(0, 0, 0, 1, 0, 0, "R8 other ignored");
        step(0, 0, 1, 0, 0, 0, "R8 suspend in erase");
        step(1, 7, 0, 1, 0, 0, "R9 held ignores");
        step(0, 0, 0, 0, 1, 0, "R9 end from held");
        // R6: foreign command clears
        step(1, 0, 0, 0, 0, 0, "R6 open");
        step(1, 15, 0, 0, 0, 0, "R6 add top");
        step(0, 0, 0, 1, 0, 0, "R6 foreign clear");
        step(0, 0, 0, 0, 0, 0, "R6 idle after");
        // R7: suspend in window
        step(1, 3, 0, 0, 0, 0, "R7 open");
        ticks(20, "R7 wait");
        step(0, 0, 1, 0, 0, 0, "R7 suspend");
        ticks(TOUT + 2, "R7 no start");
        step(0, 0, 0, 0, 1, 0, "R9 end");
        // R10: priority
        step(1, 1, 0, 0, 0, 0, "R10 open");
        step(1, 8, 1, 1, 0, 0, "R10 other wins");
        step(1, 4, 0, 0, 0, 0, "R10 reopen");
        step(1, 6, 1, 0, 0, 0, "R10 suspend beats se");
        step(0, 0, 0, 0, 1, 0, "R10 end");
        step(1, 4, 0, 0, 0, 0, "R10 open again");
        ticks(TOUT - 1, "R10 near expiry");
        step(1, 6, 0, 0, 0, 1, "R10 se on final tick");
        ticks(TOUT, "R10 R4 full window");
        step(0, 0, 0, 0, 1, 0, "R9 end after erase");
        // R3: every sector, reverse order
        for (int s = NSEC - 1; s >= 0; s--) step(1, s, 0, 0, 0, 0, "R3 fill all");
        ticks(TOUT, "R3 R5 full set erase");
        step(0, 0, 0, 0, 1, 0, "R9 final end");
        step(0, 0, 0, 0, 0, 0, "R9 idle");

        @(negedge clk);
        se_cmd = 0; susp_cmd = 0; other_cmd = 0; erase_end = 0; us_tick = 0;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule